// File: doc/BRIEF.md
# SPI Command Slave for a Counter Register Bank

This block is the serial front end of a counter core. It acts as an SPI slave in mode 0 and frames every transaction with an active-low select. The first byte of a transaction is an instruction. That instruction names one operation (clear, read, write or load) and one of six target registers. The bytes that follow carry write data into the block or read data out of it. How many data bytes a register takes depends on the register: the mode and status registers take one byte, while the data, counter and snapshot registers take the configured register width of 1 to 4 bytes.

The block does no arithmetic of its own. It reports every resulting action to the counter core on one registered strobe bus, which carries the operation, the target and, for a write, the assembled value. It reads register contents back through a select/data pair. A read of the counter first asks the core for a snapshot and then shifts the snapshot out. SCK, select and MOSI are brought into the system clock domain through synchronisers, and all edge detection is done there. MISO carries an output enable for the pad's tri-state buffer, and that enable is never asserted while select is high.

Top module: `spi_cmd_if`

## Requirements
- R1: Instruction bits 7:6 are the opcode: 00 clear, 01 read, 10 write, 11 load. Bits 5:3 select the target: 1 mode0, 2 mode1, 3 data, 4 counter, 5 snapshot, 6 status; 0 and 7 select nothing. Bits 2:0 are ignored. `cmd_op` and `cmd_reg` use the same codes.
- R2: A clear of mode0, mode1, counter or status gives exactly one strobe with op 00 and that target. A clear of any other target gives no strobe.
- R3: A load of the counter or of the snapshot gives exactly one strobe with op 11 and that target. A load of any other target gives no strobe.
- R4: A write to mode0 or mode1 takes 1 byte, and a write to the data register takes the configured width. Exactly one strobe with op 10 follows the last expected byte, and `cmd_data` holds the bytes right-aligned, first byte most significant. A write to any other target gives no strobe.
- R5: A read of mode0, mode1 or status shifts out 1 byte, and a read of the snapshot shifts out the configured width. Data goes out most significant bit and byte first, and each bit changes after a falling SCK edge. `rd_sel` names the register being read. A read of data, none, 0 or 7 shifts out zeros.
- R6: A read of the counter first gives one strobe with op 11 and target 5 (snapshot), then shifts out the snapshot for the configured width.
- R7: Bytes beyond the expected count cause no strobe and shift out zeros until select goes high and then low again.
- R8: While read data is being shifted out, MOSI has no effect: no strobe is issued.
- R9: `miso_oe` is low whenever `ss_n` is high.
- R10: `width_m1` gives the configured width as bytes minus one (0 means 1 byte, 3 means 4 bytes) for the data, counter and snapshot transfers.
- R11: After reset, `cmd_stb` and `miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, idle low |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| width_m1 | input | 2 | Configured register width in bytes minus one |
| rd_data | input | DATA_W | Contents of the register named by `rd_sel` |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO pad buffer |
| rd_sel | output | 3 | Register code whose contents are to be read |
| cmd_stb | output | 1 | One-cycle strobe for an operation |
| cmd_op | output | 2 | Opcode of the strobed operation |
| cmd_reg | output | 3 | Target code of the strobed operation |
| cmd_data | output | DATA_W | Assembled write value (zero for clear and load) |

## Verification
A strobe appears three system clocks after the SCK rising edge that completes its byte: two synchroniser stages, then the registered action. A new MISO bit appears three clocks after a falling edge. For reads, the data is captured two clocks after the instruction decode, which leaves time for the core's snapshot to settle. The bench holds each SCK phase for six clocks and samples MISO at the end of the low phase, just before it raises SCK. It does not check strobes at a fixed cycle: a monitor collects them, and the bench compares them once select has been released. That release comes several clocks after the last possible strobe time.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    OP_CLR = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_LD  = 2'b11
  } op_e;

  localparam logic [2:0] SEL_MODE0 = 3'd1;
  localparam logic [2:0] SEL_MODE1 = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_COUNT = 3'd4;
  localparam logic [2:0] SEL_SNAP  = 3'd5;
  localparam logic [2:0] SEL_STAT  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INSTR,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } state_e;

endpackage

// File: rtl/spi_cmd_sync.sv
// Synchroniser with edge detection on the synchronised level.
module spi_cmd_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= {STAGES{INIT}};
      prev <= INIT;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
  assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/spi_cmd_decode.sv
// Turns the instruction's opcode and target field into actions.
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int NB_W = 2
) (
  input  logic [4:0]      instr_hi,
  input  logic [NB_W-1:0] width_m1,
  output logic            act,
  output op_e             act_op,
  output logic [2:0]      act_reg,
  output logic            go_write,
  output logic            go_read,
  output logic [2:0]      rd_reg,
  output logic [NB_W-1:0] len_m1
);
  op_e        op;
  logic [2:0] sel;

  assign op  = op_e'(instr_hi[4:3]);
  assign sel = instr_hi[2:0];

  always_comb begin
    act      = 1'b0;
    act_op   = op;
    act_reg  = sel;
    go_write = 1'b0;
    go_read  = 1'b0;
    rd_reg   = sel;
    len_m1   = (sel == SEL_DATA || sel == SEL_COUNT || sel == SEL_SNAP) ? width_m1 : '0;
    unique case (op)
      OP_CLR: act = (sel == SEL_MODE0) || (sel == SEL_MODE1) ||
                    (sel == SEL_COUNT) || (sel == SEL_STAT);
      OP_LD:  act = (sel == SEL_COUNT) || (sel == SEL_SNAP);
      OP_WR:  go_write = (sel == SEL_MODE0) || (sel == SEL_MODE1) || (sel == SEL_DATA);
      OP_RD: begin
        go_read = (sel == SEL_MODE0) || (sel == SEL_MODE1) || (sel == SEL_COUNT) ||
                  (sel == SEL_SNAP)  || (sel == SEL_STAT);
        if (sel == SEL_COUNT) begin
          act     = 1'b1;
          act_op  = OP_LD;
          act_reg = SEL_SNAP;
          rd_reg  = SEL_SNAP;
        end
      end
      default: act = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_tx_shift.sv
// Parallel-load shifter that drives the registered MISO bit.
module spi_tx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         dout
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh   <= '0;
      dout <= 1'b0;
    end else if (load) begin
      sh <= din;
    end else if (shift) begin
      dout <= sh[W-1];
      sh   <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sck,
  input  logic                      ss_n,
  input  logic                      mosi,
  input  logic [$clog2(DATA_W/8)-1:0] width_m1,
  input  logic [DATA_W-1:0]         rd_data,
  output logic                      miso,
  output logic                      miso_oe,
  output logic [2:0]                rd_sel,
  output logic                      cmd_stb,
  output logic [1:0]                cmd_op,
  output logic [2:0]                cmd_reg,
  output logic [DATA_W-1:0]         cmd_data
);
  localparam int NBYTES = DATA_W / 8;
  localparam int NB_W   = $clog2(NBYTES);
  localparam logic [1:0] SYNC_INIT = 2'b10;  // {ss_n, sck} idle levels

  logic [1:0] raw_in, rise_v, fall_v;
  assign raw_in = {ss_n, sck};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    spi_cmd_sync #(.STAGES(SYNC_STAGES), .INIT(SYNC_INIT[g])) u_sync (
      .clk(clk), .rst(rst), .din(raw_in[g]), .rise(rise_v[g]), .fall(fall_v[g])
    );
  end

  logic sck_rise, sck_fall, ss_rise, ss_fall;
  assign sck_rise = rise_v[0];
  assign sck_fall = fall_v[0];
  assign ss_rise  = rise_v[1];
  assign ss_fall  = fall_v[1];

  // MOSI delayed to line up with the synchronised SCK level
  logic [SYNC_STAGES-1:0] mosi_d;
  always_ff @(posedge clk) begin
    if (rst) mosi_d <= '0;
    else     mosi_d <= {mosi_d[SYNC_STAGES-2:0], mosi};
  end

  state_e            state;
  logic [2:0]        bit_cnt;
  logic [NB_W-1:0]   byte_left, len_q;
  logic [2:0]        wr_reg_q;
  logic [DATA_W-1:0] rx, rx_next;
  logic [NB_W+3:0]   rd_left;
  logic [1:0]        ld_cnt;

  assign rx_next = {rx[DATA_W-2:0], mosi_d[SYNC_STAGES-1]};

  logic            dec_act, dec_go_wr, dec_go_rd;
  op_e             dec_op;
  logic [2:0]      dec_reg, dec_rd_reg;
  logic [NB_W-1:0] dec_len;

  spi_cmd_decode #(.NB_W(NB_W)) u_dec (
    .instr_hi(rx_next[7:3]), .width_m1(width_m1),
    .act(dec_act), .act_op(dec_op), .act_reg(dec_reg),
    .go_write(dec_go_wr), .go_read(dec_go_rd), .rd_reg(dec_rd_reg), .len_m1(dec_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_left <= '0;
      len_q     <= '0;
      wr_reg_q  <= '0;
      rx        <= '0;
      rd_left   <= '0;
      ld_cnt    <= '0;
      rd_sel    <= '0;
      cmd_stb   <= 1'b0;
      cmd_op    <= '0;
      cmd_reg   <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (ld_cnt != 2'd0) ld_cnt <= ld_cnt - 2'd1;
      if (ss_rise) begin
        state  <= ST_IDLE;
        ld_cnt <= '0;
      end else if (ss_fall) begin
        state   <= ST_INSTR;
        bit_cnt <= '0;
        rx      <= '0;
      end else begin
        unique case (state)
          ST_INSTR: if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx      <= rx_next;
            if (bit_cnt == 3'd7) begin
              rx        <= '0;
              cmd_stb   <= dec_act;
              cmd_op    <= dec_op;
              cmd_reg   <= dec_reg;
              cmd_data  <= '0;
              len_q     <= dec_len;
              byte_left <= dec_len;
              wr_reg_q  <= rx_next[5:3];
              if (dec_go_wr) begin
                state <= ST_WDATA;
              end else if (dec_go_rd) begin
                state   <= ST_RDATA;
                rd_sel  <= dec_rd_reg;
                ld_cnt  <= 2'd2;
                rd_left <= {1'b0, dec_len, 3'b000} + (NB_W+4)'(8);
              end else begin
                state <= ST_DONE;
              end
            end
          end
          ST_WDATA: if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx      <= rx_next;
            if (bit_cnt == 3'd7) begin
              if (byte_left == '0) begin
                cmd_stb  <= 1'b1;
                cmd_op   <= OP_WR;
                cmd_reg  <= wr_reg_q;
                cmd_data <= rx_next;
                state    <= ST_DONE;
              end else begin
                byte_left <= byte_left - 1'b1;
              end
            end
          end
          ST_RDATA: if (sck_fall) begin
            if (rd_left == '0) state <= ST_DONE;
            else               rd_left <= rd_left - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Read path: align the selected width to the top of the shifter
  logic [NB_W+2:0] tx_sh_amt;
  logic            tx_clear, tx_load, tx_shift;
  assign tx_sh_amt = {NB_W'(NBYTES-1) - len_q, 3'b000};
  assign tx_clear  = ss_rise | ss_fall | (state == ST_RDATA && sck_fall && rd_left == '0);
  assign tx_load   = (ld_cnt == 2'd1);
  assign tx_shift  = (state == ST_RDATA) && sck_fall && (rd_left != '0);

  spi_tx_shift #(.W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .clear(tx_clear), .load(tx_load),
    .din(rd_data << tx_sh_amt), .shift(tx_shift), .dout(miso)
  );

  assign miso_oe = ~ss_n & (state != ST_IDLE);
endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       ss_n,
  input logic       miso_oe,
  input logic       cmd_stb,
  input logic [1:0] cmd_op,
  input logic [2:0] cmd_reg
);
  // R9
  oe_deselect_chk: assert property (@(posedge clk) disable iff (rst) ss_n |-> !miso_oe);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst) cmd_stb |=> !cmd_stb);

  // R2
  clear_target_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_op == 2'b00) |->
      (cmd_reg == 3'd1 || cmd_reg == 3'd2 || cmd_reg == 3'd4 || cmd_reg == 3'd6));

  // R3
  load_target_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_op == 2'b11) |-> (cmd_reg == 3'd4 || cmd_reg == 3'd5));

  // R4
  write_target_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_op == 2'b10) |-> (cmd_reg == 3'd1 || cmd_reg == 3'd2 || cmd_reg == 3'd3));

  // R6
  no_read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> (cmd_op != 2'b01));
endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
  .clk(clk), .rst(rst), .ss_n(ss_n), .miso_oe(miso_oe),
  .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_reg(cmd_reg)
);

// File: tb/spi_cmd_if_tb.sv
module spi_cmd_if_tb_top;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        ss_n = 1'b1;
  logic        mosi = 1'b0;
  logic [1:0]  width_m1 = 2'd0;
  logic [31:0] rd_data;
  logic        miso, miso_oe, cmd_stb;
  logic [2:0]  rd_sel, cmd_reg;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_data;

  always #4 clk = ~clk;

  spi_cmd_if dut_i (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi), .width_m1(width_m1),
    .rd_data(rd_data), .miso(miso), .miso_oe(miso_oe), .rd_sel(rd_sel),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_data(cmd_data)
  );

  // Counter-core stand-in
  logic [7:0]  m0_m, m1_m, st_m;
  logic [31:0] cnt_m, snap_m;
  int          ev_n;
  logic [1:0]  ev_op  [16];
  logic [2:0]  ev_reg [16];
  logic [31:0] ev_dat [16];

  always_comb begin
    case (rd_sel)
      3'd1:    rd_data = {24'd0, m0_m};
      3'd2:    rd_data = {24'd0, m1_m};
      3'd5:    rd_data = snap_m;
      3'd6:    rd_data = {24'd0, st_m};
      default: rd_data = 32'd0;
    endcase
  end

  always @(negedge clk) begin
    if (rst) begin
      ev_n   <= 0;
      snap_m <= 32'd0;
    end else if (cmd_stb) begin
      ev_op[ev_n % 16]  <= cmd_op;
      ev_reg[ev_n % 16] <= cmd_reg;
      ev_dat[ev_n % 16] <= cmd_data;
      ev_n <= ev_n + 1;
      if (cmd_op == 2'b11 && cmd_reg == 3'd5) snap_m <= cnt_m;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  logic [7:0]  pl [5];
  logic [7:0]  rb [5];
  logic [31:0] exp_snap = 32'd0;

  task automatic run_txn(input int t, input logic [1:0] w, input logic [1:0] op, input logic [2:0] sel);
    logic [7:0]  instr, byt;
    int          start, len_m1, exp_n;
    logic [1:0]  e_op;
    logic [2:0]  e_reg;
    logic [31:0] e_dat, rv;
    bit          rd_ok;
    string       rq;
    width_m1 = w;
    m0_m  = 8'h40 ^ 8'(t);
    m1_m  = 8'h81 ^ 8'(t);
    st_m  = 8'hE2 ^ 8'(t);
    cnt_m = 32'h1357_9BDF + 32'(t) * 32'h0101_0103;
    for (int k = 0; k < 5; k++) pl[k] = 8'h5A ^ 8'(t * 7 + k * 29);
    instr = {op, sel, 3'(t)};
    start = ev_n;
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < 6; b++) begin
      byt = (b == 0) ? instr : pl[b-1];
      for (int i = 7; i >= 0; i--) begin
        mosi = byt[i];
        repeat (H) @(negedge clk);
        if (b > 0) rb[b-1][i] = miso;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
      end
    end
    repeat (H) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(!miso_oe, "R9 oe after deselect", {31'd0, miso_oe}, 32'd0);

    // expected strobe (R1 codes)
    len_m1 = (sel == 3 || sel == 4 || sel == 5) ? int'(w) : 0;
    exp_n = 0; e_op = op; e_reg = sel; e_dat = 32'd0;
    case (op)
      2'b00: begin exp_n = (sel == 1 || sel == 2 || sel == 4 || sel == 6) ? 1 : 0; rq = "R2"; end
      2'b11: begin exp_n = (sel == 4 || sel == 5) ? 1 : 0; rq = "R3"; end
      2'b10: begin
        exp_n = (sel == 1 || sel == 2 || sel == 3) ? 1 : 0; rq = "R4 R10 R7";
        for (int k = 0; k <= len_m1; k++) e_dat = (e_dat << 8) | 32'(pl[k]);
      end
      default: begin
        exp_n = (sel == 4) ? 1 : 0; e_op = 2'b11; e_reg = 3'd5;
        rq = (sel == 4) ? "R6" : "R8";
      end
    endcase
    chk(ev_n - start == exp_n, {rq, " strobe count"}, 32'(ev_n - start), 32'(exp_n));
    if (exp_n == 1 && ev_n - start == 1) begin
      chk(ev_op[start % 16] == e_op && ev_reg[start % 16] == e_reg,
          "R1 strobe op/reg", {27'd0, ev_op[start % 16], ev_reg[start % 16]}, {27'd0, e_op, e_reg});
      chk(ev_dat[start % 16] == e_dat, {rq, " strobe data"}, ev_dat[start % 16], e_dat);
    end

    // expected read bytes
    rd_ok = (op == 2'b01) && (sel == 1 || sel == 2 || sel == 4 || sel == 5 || sel == 6);
    case (sel)
      3'd1: rv = {24'd0, m0_m};
      3'd2: rv = {24'd0, m1_m};
      3'd4: rv = cnt_m;
      3'd5: rv = exp_snap;
      default: rv = {24'd0, st_m};
    endcase
    for (int k = 0; k < 5; k++) begin
      logic [7:0] eb;
      eb = (rd_ok && k <= len_m1) ? 8'(rv >> (8 * (len_m1 - k))) : 8'h00;
      chk(rb[k] == eb, (rd_ok && k <= len_m1) ? ((sel == 4) ? "R6 read byte" : "R5 R10 read byte")
                                             : "R7 R5 idle byte", {24'd0, rb[k]}, {24'd0, eb});
    end
    if ((op == 2'b01 && sel == 4) || (op == 2'b11 && sel == 5)) exp_snap = cnt_m;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmd_stb && !miso_oe, "R11 reset state", {30'd0, cmd_stb, miso_oe}, 32'd0);
    for (int w = 0; w < 4; w++)
      for (int op = 0; op < 4; op++)
        for (int sel = 0; sel < 8; sel++)
          run_txn(w * 32 + op * 8 + sel, 2'(w), 2'(op), 3'(sel));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule